// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block gives one UART channel automatic hardware handshaking. It sits beside a character transmitter, a character receiver and a pair of FIFOs, each up to 64 entries deep. It does not contain any of them. The surrounding logic reports its state through a few plain inputs: the receive and transmit FIFO fill levels, a flag that marks a character in flight, a one-cycle pulse at the middle of the final stop bit, and the baud tick. From these inputs and the clear-to-send pin, the block produces three outputs: the request-to-send pin, a permit that tells the transmitter whether it may start the next character, and an active-low transmit-ready indication that a DMA engine can use.

On the transmit side, CTS (active low) is synchronised first. When the automatic mode is on, CTS is sampled at the stop-bit midpoint of each character. If CTS is found deasserted there, the permit drops. While the transmitter is idle, the permit is then re-evaluated on every baud tick, so a reasserted CTS reopens the line on the next tick. On the receive side, RTS follows a two-threshold hysteresis on the receive FIFO level. When automatic RTS is off, RTS is driven by a software control bit instead. A CTS change event, which is used for the modem-status interrupt, is only produced when automatic CTS is off.

Top module: `uart_flow_ctrl`

## Requirements
- R1: With automatic CTS disabled, `tx_permit` is 1 one cycle later, whatever the state of CTS.
- R2: With automatic CTS enabled, a `stop_mid` pulse sets `tx_permit` one cycle later to 1 if the synchronised CTS is asserted (cts_n low), and to 0 if it is not.
- R3: While the permit is low and `tx_busy` is 0, each `baud_tick` re-samples the synchronised CTS, so `tx_permit` rises on the first such tick after CTS is asserted.
- R4: With automatic CTS enabled, while `tx_busy` is 1 and `stop_mid` is 0, `tx_permit` does not change, even if CTS changes or a baud tick arrives.
- R5: With automatic RTS enabled, a receive level greater than or equal to `halt_lvl` drives `rts_n` high one cycle later.
- R6: With automatic RTS enabled, a receive level less than or equal to `resume_lvl` drives `rts_n` low one cycle later. The halt threshold must be greater than the resume threshold.
- R7: With automatic RTS enabled, a receive level strictly between the two thresholds leaves `rts_n` unchanged.
- R8: With automatic RTS disabled, `rts_n` equals the inverse of `mcr_rts` one cycle later. During and right after reset, `rts_n` is high, `txrdy_n` is high, `tx_permit` is 0 and `cts_delta` is 0.
- R9: `txrdy_n` goes low one cycle after the number of free transmit locations (DEPTH minus `tx_level`) is at least `tx_trig` and the FIFO is not full.
- R10: `txrdy_n` goes high one cycle after `tx_level` equals DEPTH. While the free count is nonzero and below `tx_trig`, `txrdy_n` holds its value.
- R11: A change of the synchronised CTS produces a single one-cycle `cts_delta` pulse when automatic CTS is disabled, and no pulse when it is enabled.
- R12: CTS passes through SYNC_STAGES (default 2) register stages before use. With the default setting, a `stop_mid` pulse on either of the first two edges after `cts_n` changes still sees the old CTS value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_cts_en | input | 1 | Enables automatic transmit gating on CTS |
| auto_rts_en | input | 1 | Enables automatic RTS from the receive level |
| mcr_rts | input | 1 | Software RTS bit; 1 drives `rts_n` low when automatic RTS is off |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_busy | input | 1 | A character is being serialised |
| stop_mid | input | 1 | One-cycle pulse at the middle of the final stop bit |
| baud_tick | input | 1 | One-cycle baud clock enable |
| rx_level | input | LVL_W | Receive FIFO fill level, 0..DEPTH |
| halt_lvl | input | LVL_W | Level at which RTS is released |
| resume_lvl | input | LVL_W | Level at which RTS is reasserted |
| tx_level | input | LVL_W | Transmit FIFO fill level, 0..DEPTH |
| tx_trig | input | LVL_W | Free-space threshold for transmit-ready |
| rts_n | output | 1 | Request-to-send pin, active low |
| tx_permit | output | 1 | Transmitter may start the next character |
| txrdy_n | output | 1 | Transmit-ready, active low |
| cts_delta | output | 1 | CTS change event for the modem-status interrupt |

## Verification
The embedded assertions check the following on every cycle:
- the one-cycle response of the permit to a stop-bit midpoint;
- the permit staying frozen while a character is in flight;
- the forced permit when gating is off;
- the RTS response at or beyond each threshold;
- the software-driven RTS;
- the transmit-ready response to a full FIFO and to a satisfied free-space threshold;
- the absence of CTS change events while gating is on.

Only the bench scenarios can show the following:
- the hold behaviour between thresholds, which depends on history;
- the exact synchroniser depth;
- the reopening on the first idle tick after CTS returns;
- the count of exactly one change event per CTS edge.

// File: rtl/flow_pkg.sv
package flow_pkg;

  typedef enum logic [0:0] {
    GATE_HELD = 1'b0,
    GATE_OPEN = 1'b1
  } gate_e;

  // Receive hysteresis: halt wins at or above the upper level, resume at or
  // below the lower level, otherwise the previous state is kept.
  function automatic logic rts_next_halted(logic halted, int unsigned lvl,
                                           int unsigned halt, int unsigned resume);
    if (lvl >= halt) return 1'b1;
    if (lvl <= resume) return 1'b0;
    return halted;
  endfunction

  function automatic int unsigned free_slots(int unsigned lvl, int unsigned depth);
    return (lvl >= depth) ? 0 : depth - lvl;
  endfunction

  // Active-low ready: high on full, low once free space meets the trigger.
  function automatic logic txrdy_next(logic cur_n, int unsigned free, int unsigned trig);
    if (free == 0) return 1'b1;
    if (free >= trig) return 1'b0;
    return cur_n;
  endfunction

endpackage

// File: rtl/flow_cts_gate.sv
module flow_cts_gate
  import flow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_cts_en,
  input  logic cts_n,
  input  logic tx_busy,
  input  logic stop_mid,
  input  logic baud_tick,
  output logic tx_permit,
  output logic cts_delta
);

  localparam int SMSB = SYNC_STAGES - 1;

  logic [SMSB:0] sync_q;
  logic          cts_ok;
  logic          cts_ok_q;
  logic          idle_check;
  logic          sample_evt;
  gate_e         gate_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= cts_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[i] <= 1'b1;
          else        sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  assign cts_ok     = ~sync_q[SMSB];
  assign idle_check = baud_tick & ~tx_busy;
  assign sample_evt = stop_mid | idle_check;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gate_q <= GATE_HELD;
    else if (!auto_cts_en) gate_q <= GATE_OPEN;
    else if (sample_evt)   gate_q <= cts_ok ? GATE_OPEN : GATE_HELD;
  end

  assign tx_permit = (gate_q == GATE_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_ok_q  <= 1'b0;
      cts_delta <= 1'b0;
    end else begin
      cts_ok_q  <= cts_ok;
      cts_delta <= (cts_ok ^ cts_ok_q) & ~auto_cts_en;
    end
  end

  a_r1_permit_forced: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en |=> tx_permit);

  a_r2_stop_mid_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && stop_mid) |=> (tx_permit == $past(cts_ok)));

  a_r4_frozen_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_en && tx_busy && !stop_mid) |=> $stable(tx_permit));

  a_r11_no_event_gated: assert property (@(posedge clk) disable iff (!rst_n)
    auto_cts_en |=> !cts_delta);

endmodule

// File: rtl/flow_rts_ctrl.sv
module flow_rts_ctrl
  import flow_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_rts_en,
  input  logic             mcr_rts,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  output logic             rts_n
);

  logic halted_q;
  logic halted_d;

  assign halted_d = rts_next_halted(halted_q, 32'(rx_level), 32'(halt_lvl), 32'(resume_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      rts_n    <= 1'b1;
    end else if (auto_rts_en) begin
      halted_q <= halted_d;
      rts_n    <= halted_d;
    end else begin
      halted_q <= 1'b0;
      rts_n    <= ~mcr_rts;
    end
  end

  a_r5_halt_release: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_level >= halt_lvl) |=> rts_n);

  a_r6_resume_assert: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && halt_lvl > resume_lvl && rx_level <= resume_lvl) |=> !rts_n);

  a_r8_software_rts: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |=> (rts_n == !$past(mcr_rts)));

endmodule

// File: rtl/flow_txrdy_gen.sv
module flow_txrdy_gen
  import flow_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_trig,
  output logic             txrdy_n
);

  int unsigned free_now;
  logic        fifo_full;

  assign free_now  = free_slots(32'(tx_level), DEPTH);
  assign fifo_full = (free_now == 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txrdy_n <= 1'b1;
    else        txrdy_n <= txrdy_next(txrdy_n, free_now, 32'(tx_trig));
  end

  a_r10_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_level) >= DEPTH) |=> txrdy_n);

  a_r9_space_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_full && (DEPTH - 32'(tx_level)) >= 32'(tx_trig)) |=> !txrdy_n);

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_cts_en,
  input  logic             auto_rts_en,
  input  logic             mcr_rts,
  input  logic             cts_n,
  input  logic             tx_busy,
  input  logic             stop_mid,
  input  logic             baud_tick,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] halt_lvl,
  input  logic [LVL_W-1:0] resume_lvl,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_trig,
  output logic             rts_n,
  output logic             tx_permit,
  output logic             txrdy_n,
  output logic             cts_delta
);

  flow_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en), .cts_n(cts_n),
    .tx_busy(tx_busy), .stop_mid(stop_mid), .baud_tick(baud_tick),
    .tx_permit(tx_permit), .cts_delta(cts_delta)
  );

  flow_rts_ctrl #(.LVL_W(LVL_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .mcr_rts(mcr_rts),
    .rx_level(rx_level), .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
    .rts_n(rts_n)
  );

  flow_txrdy_gen #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_txrdy (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .tx_trig(tx_trig),
    .txrdy_n(txrdy_n)
  );

endmodule

// File: tb/sim_uart_flow_ctrl.sv
module sim_uart_flow_ctrl;

  localparam int DEPTH = 64;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int NV    = 12;

  // RTS vectors: auto, mcr bit, rx level, expected rts_n (halt 48, resume 16)
  localparam int V_AUTO[NV] = '{0, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0};
  localparam int V_MCR [NV] = '{1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1};
  localparam int V_LVL [NV] = '{0, 0, 10, 30, 48, 60, 30, 17, 16, 47, 64, 64};
  localparam int V_EXP [NV] = '{0, 1, 0, 0, 1, 1, 1, 1, 0, 0, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_cts_en = 1'b0, auto_rts_en = 1'b0, mcr_rts = 1'b0;
  logic cts_n = 1'b1, tx_busy = 1'b0, stop_mid = 1'b0, baud_tick = 1'b0;
  logic [LW-1:0] rx_level = '0, halt_lvl = 7'd48, resume_lvl = 7'd16;
  logic [LW-1:0] tx_level = '0, tx_trig = 7'd16;
  logic rts_n, tx_permit, txrdy_n, cts_delta;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  uart_flow_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
    .mcr_rts(mcr_rts), .cts_n(cts_n), .tx_busy(tx_busy), .stop_mid(stop_mid),
    .baud_tick(baud_tick), .rx_level(rx_level), .halt_lvl(halt_lvl),
    .resume_lvl(resume_lvl), .tx_level(tx_level), .tx_trig(tx_trig),
    .rts_n(rts_n), .tx_permit(tx_permit), .txrdy_n(txrdy_n), .cts_delta(cts_delta)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic count_delta(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (cts_delta) cnt++;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    @(negedge clk);
    @(negedge clk);
    // R8 reset state
    chk("R8 reset rts_n", int'(rts_n), 1);
    chk("R8 reset txrdy_n", int'(txrdy_n), 1);
    chk("R8 reset tx_permit", int'(tx_permit), 0);
    chk("R8 reset cts_delta", int'(cts_delta), 0);
    rst_n = 1'b1;

    // R5 R6 R7 R8 vector walk
    for (int v = 0; v < NV; v++) begin
      auto_rts_en = V_AUTO[v][0];
      mcr_rts     = V_MCR[v][0];
      rx_level    = LW'(V_LVL[v]);
      step(1);
      chk($sformatf("R5/R6/R7/R8 vector %0d", v), int'(rts_n), V_EXP[v]);
    end

    // R9 R10 transmit ready
    tx_level = 7'd0;  step(1); chk("R9 empty ready", int'(txrdy_n), 0);
    tx_level = 7'd50; step(1); chk("R10 hold low below trigger", int'(txrdy_n), 0);
    tx_level = 7'd64; step(1); chk("R10 full not ready", int'(txrdy_n), 1);
    tx_level = 7'd50; step(1); chk("R10 hold high below trigger", int'(txrdy_n), 1);
    tx_level = 7'd48; step(1); chk("R9 free equals trigger", int'(txrdy_n), 0);

    // R1 gating off
    auto_cts_en = 1'b0; cts_n = 1'b1; step(2);
    chk("R1 permit with CTS deasserted", int'(tx_permit), 1);
    // R11 event when gating off
    cts_n = 1'b0; count_delta(8, cnt);
    chk("R11 one event gating off", cnt, 1);
    // R11 no event when gating on
    auto_cts_en = 1'b1; cts_n = 1'b1; count_delta(8, cnt);
    chk("R11 no event gating on", cnt, 0);

    // R2 stop midpoint with CTS deasserted
    tx_busy = 1'b1; stop_mid = 1'b1; step(1); stop_mid = 1'b0;
    chk("R2 stop_mid CTS deasserted", int'(tx_permit), 0);
    // R4 tick while busy keeps hold
    cts_n = 1'b0; step(3);
    baud_tick = 1'b1; step(1); baud_tick = 1'b0;
    chk("R4 busy tick no reopen", int'(tx_permit), 0);
    // R3 idle tick without tick keeps hold, tick reopens
    tx_busy = 1'b0; step(2);
    chk("R3 no tick stays held", int'(tx_permit), 0);
    baud_tick = 1'b1; step(1); baud_tick = 1'b0;
    chk("R3 idle tick reopens", int'(tx_permit), 1);
    // R4 CTS change mid-character does not close
    tx_busy = 1'b1; cts_n = 1'b1; step(3);
    chk("R4 in-flight CTS change ignored", int'(tx_permit), 1);
    // R2 stop midpoint with CTS asserted
    cts_n = 1'b0; step(3);
    stop_mid = 1'b1; step(1); stop_mid = 1'b0;
    chk("R2 stop_mid CTS asserted", int'(tx_permit), 1);

    // R12 synchroniser depth
    cts_n = 1'b1; stop_mid = 1'b1;
    step(1); chk("R12 first edge old CTS", int'(tx_permit), 1);
    step(1); chk("R12 second edge old CTS", int'(tx_permit), 1);
    step(1); chk("R12 third edge new CTS", int'(tx_permit), 0);
    stop_mid = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule